// File: doc/BRIEF.md
# Host Handshake Frame Controller

This block runs the host side of a half-duplex, byte-serial link to a system-management microcontroller. A byte shift register moves the data bits and is outside the block. The block sees that register only through a "byte shifted" strobe, a byte it can unload, a byte it can load, and a direction control. Three sideband lines carry the byte-level handshake. The block drives an active-low frame-active line and an acknowledge line that changes level once per byte. The peripheral drives an active-low request line back to the block.

Outbound packets enter a two-entry queue. Each entry is a type byte plus payload, up to a fixed maximum size. Inbound frames leave the block as a stream of payload bytes. At the end of each inbound frame the block also presents the type byte, the payload length and an overflow flag.

If the peripheral asserts its request while the host is writing, the peripheral wins. The write is dropped and the inbound frame is taken in its place. After a settle delay the whole outbound packet is sent again from its first byte. After reset the block runs a fixed wake-up handshake on the sideband lines. A prescaled counter times every delay.

Top module: `hsk_frame_ctrl`

## Requirements
- R1: After reset the block runs a wake-up handshake. It drives frame-active low, then flips acknowledge, then drives frame-active high, then returns acknowledge high. Each step comes GAP_US*CYC_PER_US cycles after the previous one. The block accepts no traffic until the handshake is done.
- R2: While idle, frame-active is high, acknowledge is high and the direction output is 0 (input).
- R3: A shifted-byte strobe while idle with the request asserted (low) starts an inbound frame. The byte is taken as the frame type, frame-active goes low and the direction stays input.
- R4: In an inbound frame, each later strobe presents the byte on rx_byte with a one-cycle rx_valid. If the request is still asserted, acknowledge flips. If the request is released, the frame closes: both sideband outputs go high and rx_done pulses with rx_type and rx_len (total bytes minus one).
- R5: When an inbound frame reaches MAX_IN bytes (type included) with the request still asserted, the frame closes with rx_ovf=1 and rx_len=MAX_IN-1.
- R6: A write starts only from idle with the request released. The block loads byte 0 (the type) with a one-cycle sr_wr_load, sets the direction to 1 (output), keeps acknowledge high and drives frame-active low. No write starts while the request is asserted.
- R7: When a written byte has shifted out with the request released, the block loads the next byte and flips acknowledge. After pkt_len bytes it returns to idle levels and removes the packet from the queue.
- R8: If the request is asserted when a written byte finishes shifting, the write aborts. The shifted byte becomes the type of a new inbound frame, and the packet stays queued to be resent from byte 0.
- R9: When an inbound frame closes with a packet queued, the block waits SETTLE_US*CYC_PER_US cycles. It then starts the write only if the request is released. Otherwise it waits in idle for the peripheral.
- R10: The queue holds two packets, sent in push order with no gap beyond the idle restart. pkt_ready is low when the queue is full, and a push while full is dropped. Packet bytes sit at pkt_bytes[8i+7:8i] for byte i; pkt_len counts the type byte.
- R11: The request input passes through two flops. A strobe that comes one cycle after the request goes low still sees the request released and does not open a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n_in | input | 1 | Peripheral request, active low, asynchronous |
| tip_n | output | 1 | Frame-active line, active low |
| ack_o | output | 1 | Byte acknowledge, flips once per byte |
| dir_out | output | 1 | Shift direction: 1 output, 0 input |
| sr_done | input | 1 | Strobe: one byte has finished shifting |
| sr_rd_data | input | 8 | Byte unloaded from the shift register |
| sr_wr_load | output | 1 | One-cycle strobe to load sr_wr_data |
| sr_wr_data | output | 8 | Byte to load into the shift register |
| pkt_valid | input | 1 | Push an outbound packet |
| pkt_bytes | input | 8*PKT_BYTES | Packet bytes, byte 0 is the type |
| pkt_len | input | clog2(PKT_BYTES+1) | Packet byte count including type, 1..PKT_BYTES |
| pkt_ready | output | 1 | Queue has a free entry |
| rx_valid | output | 1 | Inbound payload byte present |
| rx_byte | output | 8 | Inbound payload byte |
| rx_done | output | 1 | Inbound frame closed |
| rx_type | output | 8 | Type byte of the current or last inbound frame |
| rx_len | output | clog2(MAX_IN+1) | Payload length of the closed frame |
| rx_ovf | output | 1 | Closed frame hit the length limit |

## Verification
The assertions assume the following about the inputs:
- sr_done pulses only while a frame is open, or while idle when the peripheral initiates a transfer.
- No strobe arrives during the wake-up handshake or the settle wait.
- pkt_len is never zero.

The bench models the peripheral to stay within these assumptions. Every strobe is one cycle long and is issued only after the bench has seen the matching load or sideband change. Every change on the request line is given three cycles to pass the synchronizer before a strobe depends on it. The one exception is a deliberate early strobe that checks the synchronizer latency.

// File: rtl/hsk_frame_ctrl.sv
module hsk_frame_ctrl #(
  parameter int CYC_PER_US = 50,
  parameter int GAP_US     = 150,
  parameter int SETTLE_US  = 1500,
  parameter int MAX_IN     = 256,
  parameter int PKT_BYTES  = 16,
  parameter int FIFO_DEPTH = 2,
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int CW = $clog2(MAX_IN + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_n_in,
  output logic                   tip_n,
  output logic                   ack_o,
  output logic                   dir_out,
  input  logic                   sr_done,
  input  logic [7:0]             sr_rd_data,
  output logic                   sr_wr_load,
  output logic [7:0]             sr_wr_data,
  input  logic                   pkt_valid,
  input  logic [8*PKT_BYTES-1:0] pkt_bytes,
  input  logic [LW-1:0]          pkt_len,
  output logic                   pkt_ready,
  output logic                   rx_valid,
  output logic [7:0]             rx_byte,
  output logic                   rx_done,
  output logic [7:0]             rx_type,
  output logic [CW-1:0]          rx_len,
  output logic                   rx_ovf
);

  localparam int PW   = $clog2(CYC_PER_US + 1);
  localparam int DMAX = (SETTLE_US > GAP_US) ? SETTLE_US : GAP_US;
  localparam int TW   = $clog2(DMAX + 1);
  localparam int AW   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int NW   = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [2:0] {S_INIT, S_IDLE, S_IN, S_OUT, S_SETTLE} st_t;
  st_t st;

  logic req_s1, req_s2, req;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= 1'b1;
      req_s2 <= 1'b1;
    end else begin
      req_s1 <= req_n_in;
      req_s2 <= req_s1;
    end
  assign req = ~req_s2;

  logic [8*PKT_BYTES-1:0] f_data [FIFO_DEPTH];
  logic [LW-1:0]          f_len  [FIFO_DEPTH];
  logic [AW-1:0]          wp, rp;
  logic [NW-1:0]          fcnt;
  logic                   push, pop, pending;
  logic [8*PKT_BYTES-1:0] head_d;
  logic [LW-1:0]          head_l;

  assign pkt_ready = (fcnt != NW'(FIFO_DEPTH));
  assign pending   = (fcnt != '0);
  assign push      = pkt_valid && pkt_ready;
  assign head_d    = f_data[rp];
  assign head_l    = f_len[rp];

  always_ff @(posedge clk)
    if (push) begin
      f_data[wp] <= pkt_bytes;
      f_len[wp]  <= pkt_len;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + NW'(push) - NW'(pop);
    end

  logic [PW-1:0] pre;
  logic [TW-1:0] tmr;
  logic          tmr_done;
  assign tmr_done = (tmr == '0) && (pre == PW'(CYC_PER_US - 1));

  logic [1:0]    step;
  logic [LW-1:0] sent, sent_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [7:0]    nx_byte;
  assign sent_nx = sent + 1'b1;
  assign cnt_nx  = cnt + 1'b1;
  assign nx_byte = head_d[int'(sent_nx)*8 +: 8];
  assign pop     = (st == S_OUT) && sr_done && !req && (sent_nx == head_l);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_INIT;
      tip_n      <= 1'b1;
      ack_o      <= 1'b1;
      dir_out    <= 1'b0;
      step       <= '0;
      pre        <= '0;
      tmr        <= TW'(GAP_US - 1);
      sent       <= '0;
      cnt        <= '0;
      sr_wr_load <= 1'b0;
      sr_wr_data <= '0;
      rx_valid   <= 1'b0;
      rx_byte    <= '0;
      rx_done    <= 1'b0;
      rx_type    <= '0;
      rx_len     <= '0;
      rx_ovf     <= 1'b0;
    end else begin
      sr_wr_load <= 1'b0;
      rx_valid   <= 1'b0;
      rx_done    <= 1'b0;
      if (pre == PW'(CYC_PER_US - 1)) begin
        pre <= '0;
        if (tmr != '0) tmr <= tmr - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      case (st)
        S_INIT: if (tmr_done) begin
          step <= step + 1'b1;
          tmr  <= TW'(GAP_US - 1);
          pre  <= '0;
          case (step)
            2'd0: tip_n <= 1'b0;
            2'd1: ack_o <= ~ack_o;
            2'd2: tip_n <= 1'b1;
            default: begin
              ack_o <= 1'b1;
              tip_n <= 1'b1;
              st    <= S_IDLE;
            end
          endcase
        end
        S_IDLE: begin
          if (sr_done && req) begin
            rx_type <= sr_rd_data;
            rx_ovf  <= 1'b0;
            dir_out <= 1'b0;
            tip_n   <= 1'b0;
            cnt     <= CW'(1);
            st      <= S_IN;
          end else if (pending && !req) begin
            sent       <= '0;
            sr_wr_data <= head_d[7:0];
            sr_wr_load <= 1'b1;
            dir_out    <= 1'b1;
            ack_o      <= 1'b1;
            tip_n      <= 1'b0;
            st         <= S_OUT;
          end
        end
        S_IN: if (sr_done) begin
          rx_valid <= 1'b1;
          rx_byte  <= sr_rd_data;
          cnt      <= cnt_nx;
          if (!req || cnt_nx == CW'(MAX_IN)) begin
            tip_n   <= 1'b1;
            ack_o   <= 1'b1;
            rx_done <= 1'b1;
            rx_len  <= cnt;
            rx_ovf  <= req;
            if (pending) begin
              st  <= S_SETTLE;
              tmr <= TW'(SETTLE_US - 1);
              pre <= '0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            ack_o <= ~ack_o;
          end
        end
        S_SETTLE: if (tmr_done) begin
          if (!req) begin
            sent       <= '0;
            sr_wr_data <= head_d[7:0];
            sr_wr_load <= 1'b1;
            dir_out    <= 1'b1;
            ack_o      <= 1'b1;
            tip_n      <= 1'b0;
            st         <= S_OUT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_OUT: if (sr_done) begin
          if (req) begin
            rx_type <= sr_rd_data;
            rx_ovf  <= 1'b0;
            dir_out <= 1'b0;
            tip_n   <= 1'b0;
            ack_o   <= 1'b1;
            sent    <= '0;
            cnt     <= CW'(1);
            st      <= S_IN;
          end else if (sent_nx == head_l) begin
            dir_out <= 1'b0;
            tip_n   <= 1'b1;
            ack_o   <= 1'b1;
            st      <= S_IDLE;
          end else begin
            sent       <= sent_nx;
            sr_wr_data <= nx_byte;
            sr_wr_load <= 1'b1;
            ack_o      <= ~ack_o;
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (tip_n && ack_o && !dir_out)); // R2
  AST_RX_DIR_IN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !dir_out); // R4
  AST_LOAD_DIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_load |-> (dir_out && !tip_n)); // R6
  AST_TX_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_out) |-> $past(req_s2)); // R6
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_len < CW'(MAX_IN))); // R5
  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_ovf) |-> (rx_len == CW'(MAX_IN - 1))); // R5
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= NW'(FIFO_DEPTH)); // R10

endmodule

// File: tb/test_hsk_frame_ctrl.sv
module test_hsk_frame_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 2, GAP = 4, SETTLE = 20, MAXIN = 6, PB = 16, DEPTH = 2;
  localparam int LW = $clog2(PB + 1);
  localparam int CW = $clog2(MAXIN + 1);

  logic clk = 0, rst_n = 0, req_n_in = 1, sr_done = 0, pkt_valid = 0;
  logic [7:0] sr_rd_data = 0;
  logic [8*PB-1:0] pkt_bytes = '0;
  logic [LW-1:0] pkt_len = '0;
  logic tip_n, ack_o, dir_out, sr_wr_load, pkt_ready, rx_valid, rx_done, rx_ovf;
  logic [7:0] sr_wr_data, rx_byte, rx_type;
  logic [CW-1:0] rx_len;

  int checks = 0, fails = 0, ld_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsk_frame_ctrl #(.CYC_PER_US(CYC), .GAP_US(GAP), .SETTLE_US(SETTLE),
    .MAX_IN(MAXIN), .PKT_BYTES(PB), .FIFO_DEPTH(DEPTH)) i_hsk_frame_ctrl (
    .clk(clk), .rst_n(rst_n), .req_n_in(req_n_in), .tip_n(tip_n), .ack_o(ack_o),
    .dir_out(dir_out), .sr_done(sr_done), .sr_rd_data(sr_rd_data),
    .sr_wr_load(sr_wr_load), .sr_wr_data(sr_wr_data), .pkt_valid(pkt_valid),
    .pkt_bytes(pkt_bytes), .pkt_len(pkt_len), .pkt_ready(pkt_ready),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_done(rx_done), .rx_type(rx_type),
    .rx_len(rx_len), .rx_ovf(rx_ovf));

  always @(posedge clk) if (sr_wr_load) ld_cnt <= ld_cnt + 1;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_done(input logic [7:0] b);
    @(negedge clk); sr_done = 1; sr_rd_data = b;
    @(negedge clk); sr_done = 0;
  endtask

  task automatic push(input int len, input logic [7:0] b0, b1, b2);
    @(negedge clk);
    pkt_bytes = '0;
    pkt_bytes[7:0] = b0; pkt_bytes[15:8] = b1; pkt_bytes[23:16] = b2;
    pkt_len = LW'(len); pkt_valid = 1;
    @(negedge clk); pkt_valid = 0;
  endtask

  task automatic wait_sig(ref logic s, input logic v, output int n);
    n = 0;
    while (s !== v && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_load(output int n);
    n = 0;
    while (sr_wr_load !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset;
    int n;
    rst_n = 0; cyc(3);
    chk_eq("R1 reset tip", tip_n, 1);
    chk_eq("R1 reset ack", ack_o, 1);
    @(negedge clk); rst_n = 1;
    wait_sig(tip_n, 1'b0, n); chk_rng("R1 tip low gap", n, GAP*CYC-1, GAP*CYC+2);
    wait_sig(ack_o, 1'b0, n); chk_rng("R1 ack flip gap", n, GAP*CYC-1, GAP*CYC+2);
    wait_sig(tip_n, 1'b1, n); chk_rng("R1 tip high gap", n, GAP*CYC-1, GAP*CYC+2);
    wait_sig(ack_o, 1'b1, n); chk_rng("R1 ack high gap", n, GAP*CYC-1, GAP*CYC+2);
    cyc(2);
    chk_eq("R2 idle tip", tip_n, 1);
    chk_eq("R2 idle ack", ack_o, 1);
    chk_eq("R2 idle dir", dir_out, 0);
  endtask

  task automatic t_inbound;
    req_n_in = 0;
    pulse_done(8'h7e);
    chk_eq("R11 early strobe no frame", tip_n, 1);
    cyc(3);
    pulse_done(8'h81);
    chk_eq("R3 tip low", tip_n, 0);
    chk_eq("R3 dir in", dir_out, 0);
    chk_eq("R3 type", rx_type, 8'h81);
    pulse_done(8'h11);
    chk_eq("R4 valid", rx_valid, 1);
    chk_eq("R4 byte", rx_byte, 8'h11);
    chk_eq("R4 ack flip", ack_o, 0);
    pulse_done(8'h22);
    chk_eq("R4 ack flip2", ack_o, 1);
    req_n_in = 1; cyc(3);
    pulse_done(8'h33);
    chk_eq("R4 done", rx_done, 1);
    chk_eq("R4 last byte", rx_byte, 8'h33);
    chk_eq("R4 len", rx_len, 3);
    chk_eq("R4 ovf", rx_ovf, 0);
    chk_eq("R4 tip end", tip_n, 1);
    chk_eq("R4 ack end", ack_o, 1);
  endtask

  task automatic t_overflow;
    req_n_in = 0; cyc(3);
    pulse_done(8'h42);
    for (int i = 1; i < MAXIN; i++) begin
      pulse_done(8'(i));
      if (i < MAXIN - 1) chk_eq("R5 no early done", rx_done, 0);
    end
    chk_eq("R5 done", rx_done, 1);
    chk_eq("R5 ovf", rx_ovf, 1);
    chk_eq("R5 len", rx_len, MAXIN - 1);
    chk_eq("R5 tip", tip_n, 1);
    req_n_in = 1; cyc(3);
  endtask

  task automatic t_outbound;
    int n, base;
    push(3, 8'ha0, 8'hb1, 8'hc2);
    wait_load(n);
    chk_rng("R6 start latency", n, 0, 3);
    chk_eq("R6 byte0", sr_wr_data, 8'ha0);
    chk_eq("R6 dir", dir_out, 1);
    chk_eq("R6 tip", tip_n, 0);
    chk_eq("R6 ack", ack_o, 1);
    pulse_done(8'h00);
    chk_eq("R7 load1", sr_wr_load, 1);
    chk_eq("R7 byte1", sr_wr_data, 8'hb1);
    chk_eq("R7 ack flip", ack_o, 0);
    pulse_done(8'h00);
    chk_eq("R7 byte2", sr_wr_data, 8'hc2);
    chk_eq("R7 ack flip2", ack_o, 1);
    pulse_done(8'h00);
    chk_eq("R7 no load", sr_wr_load, 0);
    chk_eq("R7 tip end", tip_n, 1);
    chk_eq("R7 dir end", dir_out, 0);
    cyc(2); base = ld_cnt; cyc(8);
    chk_eq("R7 packet popped", ld_cnt, base);
  endtask

  task automatic t_collision;
    int n;
    push(3, 8'h55, 8'h66, 8'h77);
    wait_load(n);
    chk_eq("R8 first byte", sr_wr_data, 8'h55);
    pulse_done(8'h00);
    chk_eq("R8 second byte", sr_wr_data, 8'h66);
    req_n_in = 0; cyc(3);
    pulse_done(8'h90);
    chk_eq("R8 abort no load", sr_wr_load, 0);
    chk_eq("R8 abort dir", dir_out, 0);
    chk_eq("R8 abort tip", tip_n, 0);
    chk_eq("R8 abort ack", ack_o, 1);
    chk_eq("R8 abort type", rx_type, 8'h90);
    req_n_in = 1; cyc(3);
    pulse_done(8'h01);
    chk_eq("R8 rx done", rx_done, 1);
    chk_eq("R8 rx len", rx_len, 1);
    wait_load(n);
    chk_rng("R9 settle wait", n, SETTLE*CYC-2, SETTLE*CYC+3);
    chk_eq("R8 restart byte0", sr_wr_data, 8'h55);
    pulse_done(8'h00);
    chk_eq("R8 resend byte1", sr_wr_data, 8'h66);
    pulse_done(8'h00);
    chk_eq("R8 resend byte2", sr_wr_data, 8'h77);
    pulse_done(8'h00);
    chk_eq("R8 write done", tip_n, 1);
  endtask

  task automatic t_settle_busy;
    int n, base;
    req_n_in = 0; cyc(3);
    base = ld_cnt;
    push(2, 8'hd0, 8'hee, 8'h00);
    cyc(6);
    chk_eq("R6 held while request", ld_cnt, base);
    chk_eq("R6 dir held", dir_out, 0);
    pulse_done(8'h91);
    req_n_in = 1; cyc(3);
    pulse_done(8'h02);
    chk_eq("R9 frame closed", rx_done, 1);
    req_n_in = 0;
    cyc(SETTLE*CYC + 6);
    chk_eq("R9 no start on busy", ld_cnt, base);
    chk_eq("R9 idle tip", tip_n, 1);
    pulse_done(8'h93);
    chk_eq("R9 new frame", tip_n, 0);
    req_n_in = 1; cyc(3);
    pulse_done(8'h04);
    wait_load(n);
    chk_rng("R9 second settle", n, SETTLE*CYC-2, SETTLE*CYC+3);
    chk_eq("R9 byte0", sr_wr_data, 8'hd0);
    pulse_done(8'h00);
    chk_eq("R9 byte1", sr_wr_data, 8'hee);
    pulse_done(8'h00);
    chk_eq("R9 done", dir_out, 0);
  endtask

  task automatic t_fifo;
    int n, base;
    req_n_in = 0; cyc(3);
    base = ld_cnt;
    push(1, 8'ha1, 8'h00, 8'h00);
    push(2, 8'hb2, 8'hb3, 8'h00);
    chk_eq("R10 full", pkt_ready, 0);
    push(1, 8'hc0, 8'h00, 8'h00);
    req_n_in = 1;
    wait_load(n);
    chk_eq("R10 first pkt", sr_wr_data, 8'ha1);
    pulse_done(8'h00);
    chk_eq("R7 len1 end", tip_n, 1);
    wait_load(n);
    chk_rng("R10 back to back", n, 0, 3);
    chk_eq("R10 second pkt", sr_wr_data, 8'hb2);
    pulse_done(8'h00);
    chk_eq("R10 second byte1", sr_wr_data, 8'hb3);
    pulse_done(8'h00);
    cyc(10);
    chk_eq("R10 full push dropped", ld_cnt, base + 3);
    chk_eq("R10 ready again", pkt_ready, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_inbound();
    t_overflow();
    t_outbound();
    t_collision();
    t_settle_busy();
    t_fifo();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule